// File: doc/BRIEF.md
# Octal Flash Burst-Read Prefetcher

This block sits between a memory-mapped read port and the receive side of an octal serial flash. The flash delivers one byte per transfer. A receive FIFO collects the bytes, and a packer joins four of them into a 32-bit word. The block acknowledges bus read beats directly from that speculative stream. It keeps a pointer to the next word address the stream will supply. When a request matches that pointer, it is answered from the stream. When a request does not match, the stream is thrown away, and a new read command carrying the requested address is sent to the transmit sequencer.

The controller is a four-state machine:
- `ST_IDLE`: no valid stream exists. This is the state after reset. Any access moves it to `ST_REQ`.
- `ST_REQ`: the command request is held until the sequencer accepts it. The FIFO and packer are held clear for the whole state. When `cmd_ack` arrives, the machine goes to `ST_STREAM`.
- `ST_STREAM`: requests are served.
  - A matching beat tagged as incrementing burst stays in `ST_STREAM`.
  - A matching beat with any other tag (end of burst, classic single) goes to `ST_HOLD`.
  - A non-matching access goes back to `ST_REQ`.
- `ST_HOLD`: no acknowledge is given while the strobe stays high. When the strobe drops, the machine returns to `ST_STREAM`.

Each command also carries a wait-cycle count. This count is sampled from a configuration input at the moment the request is launched.

Top module: `octrd_prefetch`

## Requirements
- R1: After synchronous reset, `bus_ack`, `cmd_req` and `rx_run` are 0, and the next-address pointer is invalid. The first access after reset always issues a new command, even at the address the stream would have supplied next.
- R2: A command is launched when an access finds no valid stream or a mismatching address. `cmd_req` then stays high, with `cmd_adr` equal to the requested word address and `cmd_dummy` equal to the value `cfg_dummy` had at launch, until `cmd_ack` is seen.
- R3: Bytes are packed little-endian. The first byte received after a command goes to bits 7:0, and the fourth goes to bits 31:24.
- R4: A beat with `bus_cti` = 2 at the pointer address is acknowledged with a one-cycle `bus_ack` once a packed word is available. The pointer then advances by one word, and the next beat of the burst is served without a new command.
- R5: A beat with `bus_cti` = 7 is acknowledged like a burst beat. After it, no acknowledge is given until `bus_stb` has been low for at least one cycle.
- R6: An access whose address differs from the pointer discards all buffered bytes, including any that arrive before `cmd_ack`. Its data then comes from the new stream at the requested address.
- R7: After a command, no beat is acknowledged before four fresh bytes have been received and packed.
- R8: A classic cycle (`bus_cti` = 0) at the pointer address is served from the stream without a command and ends like an end of burst. At any other address, it triggers a restart.
- R9: The FIFO holds 8 bytes. `rx_run` is 0 while it is full, while no stream is active, and during `ST_REQ`. Bytes held back this way are delivered later without loss or reordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Bus read strobe |
| bus_adr | input | 24 | Requested word address |
| bus_cti | input | 3 | Cycle-type tag: 0 classic, 2 incrementing burst, 7 end of burst |
| bus_ack | output | 1 | One-cycle beat acknowledge |
| bus_dat | output | 32 | Read data, valid with `bus_ack` |
| cfg_dummy | input | 5 | Wait-cycle count for the next command |
| cmd_req | output | 1 | Read command request to the transmit sequencer |
| cmd_adr | output | 24 | Start word address of the command |
| cmd_dummy | output | 5 | Wait-cycle count of the command |
| cmd_ack | input | 1 | Sequencer accepted the command |
| rx_valid | input | 1 | A received flash byte is present |
| rx_byte | input | 8 | Received flash byte |
| rx_run | output | 1 | Flash transfer enable; 0 stops the byte stream |

## Verification
An access that matches the stream and finds a packed word ready is acknowledged one cycle after it is presented. Its data sits on `bus_dat` in that same cycle. A new beat can be served no earlier than two cycles after the previous acknowledge.

A mismatch raises `cmd_req` on the next clock edge. Data for that access then waits for the command handshake, the configured wait cycles, four bytes, and one packing edge.

The bench drives inputs and samples outputs on falling edges, so it sees each registered result in the half cycle after the edge that produced it. A scoreboard queue takes the expected word when a beat is presented and compares it when `bus_ack` appears. Because of this, variable flash latency never moves a check.

// File: rtl/octrd_pkg.sv
package octrd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_STREAM,
        ST_HOLD
    } rdst_t;

    localparam logic [2:0] CTI_CLASSIC = 3'd0;
    localparam logic [2:0] CTI_INCR    = 3'd2;
    localparam logic [2:0] CTI_END     = 3'd7;
endpackage

// File: rtl/octrd_rxfifo.sv
module octrd_rxfifo #(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       push,
    input  logic [7:0] din,
    input  logic       pop,
    output logic [7:0] dout,
    output logic       empty,
    output logic       full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_q] <= din;
                wr_q      <= wr_q + 1'b1;
            end
            if (pop_ok) begin
                rd_q <= rd_q + 1'b1;
            end
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // Level tracks accepted pushes and pops; a full FIFO never grows (R9)
    p_level_r9: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt_q == $past(cnt_q) + CW'($past(push_ok)) - CW'($past(pop_ok))));
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> (cnt_q == CW'(DEPTH) || $past(clr)));
endmodule

// File: rtl/octrd_packer.sv
module octrd_packer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              take,
    output logic [WORD_W-1:0] word,
    output logic              word_valid
);
    localparam int BPW = WORD_W / 8;
    localparam int LW  = $clog2(BPW);

    logic [LW-1:0]     lane_q;
    logic [WORD_W-1:0] word_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lane_q  <= '0;
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            if (take) begin
                valid_q <= 1'b0;
            end
            if (byte_vld) begin
                word_q[{lane_q, 3'b000} +: 8] <= byte_in;
                lane_q <= lane_q + 1'b1;
                if (lane_q == LW'(BPW - 1)) begin
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign word       = word_q;
    assign word_valid = valid_q;

    // A word completes only when the last lane is written (R3)
    p_full_word_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> (lane_q == '0));
    p_no_pack_on_valid_r7: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> !byte_vld);
endmodule

// File: rtl/octrd_ctrl.sv
module octrd_ctrl
    import octrd_pkg::*;
#(
    parameter int AW  = 24,
    parameter int DCW = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_cyc,
    input  logic           bus_stb,
    input  logic [AW-1:0]  bus_adr,
    input  logic [2:0]     bus_cti,
    input  logic           word_valid,
    input  logic [DCW-1:0] cfg_dummy,
    input  logic           cmd_ack,
    output logic           take,
    output logic           flush,
    output logic           bus_ack,
    output logic           cmd_req,
    output logic [AW-1:0]  cmd_adr,
    output logic [DCW-1:0] cmd_dummy,
    output logic           stream_on
);
    rdst_t          state_q, state_d;
    logic           ack_q;
    logic           ptr_ok_q;
    logic [AW-1:0]  ptr_q;
    logic [AW-1:0]  req_adr_q;
    logic [DCW-1:0] dummy_q;
    logic           access, hit, launch;

    assign access = bus_cyc && bus_stb && !ack_q;
    assign hit    = ptr_ok_q && (bus_adr == ptr_q);

    // next-state and decode
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        launch  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (access) begin
                    launch  = 1'b1;
                    state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                if (cmd_ack) state_d = ST_STREAM;
            end
            ST_STREAM: begin
                if (access && !hit) begin
                    launch  = 1'b1;
                    state_d = ST_REQ;
                end else if (access && word_valid) begin
                    take = 1'b1;
                    if (bus_cti != CTI_INCR) state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!bus_stb) state_d = ST_STREAM;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q     <= 1'b0;
            ptr_ok_q  <= 1'b0;
            ptr_q     <= '0;
            req_adr_q <= '0;
            dummy_q   <= '0;
        end else begin
            ack_q <= take;
            if (take) ptr_q <= ptr_q + 1'b1;
            if (launch) begin
                req_adr_q <= bus_adr;
                dummy_q   <= cfg_dummy;
                ptr_ok_q  <= 1'b0;
            end
            if (state_q == ST_REQ && cmd_ack) begin
                ptr_q    <= req_adr_q;
                ptr_ok_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        bus_ack   = ack_q;
        cmd_req   = (state_q == ST_REQ);
        cmd_adr   = req_adr_q;
        cmd_dummy = dummy_q;
        stream_on = (state_q == ST_STREAM) || (state_q == ST_HOLD);
        flush     = launch || (state_q == ST_REQ);
    end

    p_ack_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q);
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_adr) && $stable(cmd_dummy)));
    p_hold_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |=> !ack_q);
    p_no_ack_in_req_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> !bus_ack);
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!bus_ack && !cmd_req && !stream_on));
endmodule

// File: rtl/octrd_prefetch.sv
module octrd_prefetch #(
    parameter int AW         = 24,
    parameter int DCW        = 5,
    parameter int FIFO_DEPTH = 8,
    parameter int WORD_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic [AW-1:0]     bus_adr,
    input  logic [2:0]        bus_cti,
    output logic              bus_ack,
    output logic [WORD_W-1:0] bus_dat,
    input  logic [DCW-1:0]    cfg_dummy,
    output logic              cmd_req,
    output logic [AW-1:0]     cmd_adr,
    output logic [DCW-1:0]    cmd_dummy,
    input  logic              cmd_ack,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_run
);
    logic              take, flush, stream_on;
    logic              f_empty, f_full, f_pop;
    logic [7:0]        f_dout;
    logic [WORD_W-1:0] word;
    logic              word_valid;
    logic [WORD_W-1:0] dat_q;

    assign f_pop  = !f_empty && !word_valid && !flush;
    assign rx_run = stream_on && !f_full;

    octrd_ctrl #(.AW(AW), .DCW(DCW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_cyc   (bus_cyc),
        .bus_stb   (bus_stb),
        .bus_adr   (bus_adr),
        .bus_cti   (bus_cti),
        .word_valid(word_valid),
        .cfg_dummy (cfg_dummy),
        .cmd_ack   (cmd_ack),
        .take      (take),
        .flush     (flush),
        .bus_ack   (bus_ack),
        .cmd_req   (cmd_req),
        .cmd_adr   (cmd_adr),
        .cmd_dummy (cmd_dummy),
        .stream_on (stream_on)
    );

    octrd_rxfifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .clr  (flush),
        .push (rx_valid),
        .din  (rx_byte),
        .pop  (f_pop),
        .dout (f_dout),
        .empty(f_empty),
        .full (f_full)
    );

    octrd_packer #(.WORD_W(WORD_W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .clr       (flush),
        .byte_vld  (f_pop),
        .byte_in   (f_dout),
        .take      (take),
        .word      (word),
        .word_valid(word_valid)
    );

    always_ff @(posedge clk) begin
        if (rst)       dat_q <= '0;
        else if (take) dat_q <= word;
    end
    assign bus_dat = dat_q;

    // An acknowledge always follows a completed packed word (R7)
    p_ack_has_word_r7: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> $past(word_valid));
    p_run_stops_full_r9: assert property (@(posedge clk) disable iff (rst)
        (f_full && !f_pop) |=> (!rx_run || $past(flush)));
endmodule

// File: tb/sim_octrd_prefetch.sv
module sim_octrd_prefetch;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DCW = 5;
    localparam int WATCHDOG = 20000;

    logic           clk = 1'b0;
    logic           rst;
    logic           bus_cyc, bus_stb;
    logic [AW-1:0]  bus_adr;
    logic [2:0]     bus_cti;
    logic           bus_ack;
    logic [31:0]    bus_dat;
    logic [DCW-1:0] cfg_dummy;
    logic           cmd_req;
    logic [AW-1:0]  cmd_adr;
    logic [DCW-1:0] cmd_dummy;
    logic           cmd_ack;
    logic           rx_valid;
    logic [7:0]     rx_byte;
    logic           rx_run;

    int n_checks = 0;
    int n_fail   = 0;
    int ncmd     = 0;
    int fresh    = 0;
    int beats_since_cmd = 0;
    logic [AW-1:0]  last_cmd_adr;
    logic [DCW-1:0] last_dummy;
    logic [31:0]    expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    octrd_prefetch u0 (
        .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
        .bus_adr(bus_adr), .bus_cti(bus_cti), .bus_ack(bus_ack), .bus_dat(bus_dat),
        .cfg_dummy(cfg_dummy), .cmd_req(cmd_req), .cmd_adr(cmd_adr),
        .cmd_dummy(cmd_dummy), .cmd_ack(cmd_ack), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_run(rx_run)
    );

    function automatic logic [7:0] fb(input int n);
        return 8'(n * 37 + 11);
    endfunction

    // little-endian word: first byte in bits 7:0 (R3)
    function automatic logic [31:0] exp_word(input logic [AW-1:0] w);
        int b;
        b = int'(w) * 4;
        return {fb(b + 3), fb(b + 2), fb(b + 1), fb(b)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // flash model: accepts commands, waits the wait cycles, streams bytes while rx_run
    initial begin
        int idx = 0;
        int dly = 0;
        bit streaming = 0;
        cmd_ack = 0; rx_valid = 0; rx_byte = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                cmd_ack = 0; rx_valid = 0; streaming = 0;
            end else if (cmd_req && !cmd_ack) begin
                cmd_ack = 1; rx_valid = 0;
                idx = int'(cmd_adr) * 4;
                dly = int'(cmd_dummy);
                streaming = 1;
                ncmd++;
                last_cmd_adr = cmd_adr;
                last_dummy = cmd_dummy;
                fresh = 0;
                beats_since_cmd = 0;
            end else begin
                cmd_ack = 0;
                if (streaming && dly > 0) begin
                    dly--;
                    rx_valid = 0;
                end else if (streaming && rx_run) begin
                    rx_valid = 1;
                    rx_byte = fb(idx);
                    idx++;
                    fresh++;
                end else begin
                    rx_valid = 0;
                end
            end
        end
    end

    // monitor: scoreboard compare on each acknowledge
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                if (expq.size() == 0) begin
                    chk(0, "R5 unexpected ack", bus_dat, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    chk(bus_dat == e, "R4 R3 beat data", bus_dat, e);
                end
                if (beats_since_cmd == 0)
                    chk(fresh >= 4, "R7 fresh bytes before first ack", 32'(fresh), 32'd4);
                beats_since_cmd++;
            end
        end
    end

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                chk(0, "watchdog", 32'(cyc), 32'(WATCHDOG));
                finish_run();
            end
        end
    end

    task automatic beat(input logic [AW-1:0] a, input logic [2:0] cti);
        int guard = 0;
        bus_cyc = 1; bus_stb = 1; bus_adr = a; bus_cti = cti;
        expq.push_back(exp_word(a));
        forever begin
            @(negedge clk);
            if (bus_ack) break;
            guard++;
            if (guard > 300) begin
                chk(0, "R4 ack timeout", 32'(a), 32'h1);
                break;
            end
        end
    endtask

    task automatic end_cycle;
        bus_cyc = 0; bus_stb = 0;
        @(negedge clk);
    endtask

    initial begin
        int c0;
        rst = 1; bus_cyc = 0; bus_stb = 0; bus_adr = '0; bus_cti = 3'd0; cfg_dummy = 5'd3;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!bus_ack, "R1 ack after reset", 32'(bus_ack), 0);
        chk(!cmd_req, "R1 cmd_req after reset", 32'(cmd_req), 0);
        chk(!rx_run, "R1 rx_run after reset", 32'(rx_run), 0);

        // first burst: launches a command (R2), tags 2,2,2,7
        beat(24'h10, 3'd2);
        chk(ncmd == 1, "R2 command count", 32'(ncmd), 1);
        chk(last_cmd_adr == 24'h10, "R2 command address", 32'(last_cmd_adr), 32'h10);
        chk(last_dummy == 5'd3, "R2 wait count", 32'(last_dummy), 3);
        beat(24'h11, 3'd2);
        beat(24'h12, 3'd2);
        beat(24'h13, 3'd7);
        // keep strobe high after end of burst: no ack (R5)
        bus_adr = 24'h14; bus_cti = 3'd2;
        repeat (3) begin
            @(negedge clk);
            chk(!bus_ack, "R5 hold after end of burst", 32'(bus_ack), 0);
        end
        end_cycle();

        // sequential continuation, no new command (R4)
        beat(24'h14, 3'd2);
        beat(24'h15, 3'd7);
        end_cycle();
        chk(ncmd == 1, "R4 no restart on sequential burst", 32'(ncmd), 1);

        // classic single at pointer (R8)
        beat(24'h16, 3'd0);
        end_cycle();
        chk(ncmd == 1, "R8 classic hit served from stream", 32'(ncmd), 1);

        // idle: stream fills and halts (R9)
        repeat (30) @(negedge clk);
        chk(!rx_run, "R9 rx_run low when FIFO full", 32'(rx_run), 0);
        beat(24'h17, 3'd2);
        beat(24'h18, 3'd2);
        beat(24'h19, 3'd2);
        beat(24'h1A, 3'd7);
        end_cycle();
        chk(ncmd == 1, "R9 no restart after stall", 32'(ncmd), 1);

        // mismatch burst with new wait count (R6, R2, R7)
        cfg_dummy = 5'd9;
        beat(24'h40, 3'd2);
        cfg_dummy = 5'd1;
        chk(ncmd == 2, "R6 restart on mismatch", 32'(ncmd), 2);
        chk(last_cmd_adr == 24'h40, "R6 restart address", 32'(last_cmd_adr), 32'h40);
        chk(last_dummy == 5'd9, "R2 wait count latched at launch", 32'(last_dummy), 9);
        beat(24'h41, 3'd7);
        end_cycle();

        // classic single off the stream (R8)
        c0 = ncmd;
        beat(24'h80, 3'd0);
        end_cycle();
        chk(ncmd == c0 + 1, "R8 classic miss restarts", 32'(ncmd), 32'(c0 + 1));
        chk(last_cmd_adr == 24'h80, "R8 classic miss address", 32'(last_cmd_adr), 32'h80);

        // reset invalidates pointer (R1)
        repeat (5) @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!rx_run && !cmd_req, "R1 idle after second reset", 32'({rx_run, cmd_req}), 0);
        c0 = ncmd;
        beat(24'h81, 3'd0);
        end_cycle();
        chk(ncmd == c0 + 1, "R1 fresh command after reset", 32'(ncmd), 32'(c0 + 1));
        chk(last_cmd_adr == 24'h81, "R1 fresh command address", 32'(last_cmd_adr), 32'h81);

        repeat (5) @(negedge clk);
        chk(expq.size() == 0, "R4 all beats acknowledged", 32'(expq.size()), 0);
        finish_run();
    end
endmodule